// File: doc/BRIEF.md
# PCI Target Transaction Sequencer

This block is the target-side control core of a PCI agent. It watches the sampled bus control inputs, recognises each address phase, decides whether the agent claims the transaction, and drives the three target-owned sustained tri-state signals (DEVSEL#, TRDY#, STOP#) with their output enables. It also emits a one-cycle strobe to a register file for every completed data transfer. Parity, AD bus data and register contents are handled elsewhere.

The configuration and I/O paths behind this block handle only single transfers. Bursts of those types are legal on the bus, so every claimed configuration or I/O access ends with a disconnect-with-data: STOP# goes low in the same clock as TRDY#. Memory accesses run as bursts until the initiator ends them. STOP# is driven in every claimed transaction. A new address phase that arrives right after a completed transaction, with no idle clock between them, is decoded and accepted whatever the fast back-to-back enable bit says.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: After reset, devsel_n, trdy_n and stop_n are high, all three enables are low and rf_strobe is low.
- R2: An address phase is the first clock with frame_n low after a clock with frame_n high. The block claims a configuration access for cmd 4'b1010 or 4'b1011 with idsel high and ad_low equal to 2'b00, an I/O access for cmd 4'b0010 or 4'b0011 with hit high, and a memory access for cmd 4'b0110, 4'b0111, 4'b1100, 4'b1110 or 4'b1111 with hit high. Any other address phase leaves all outputs released.
- R3: For a claimed access, devsel_n goes low and all three enables go high in the second clock after the address phase. Nothing is driven in the first clock after it.
- R4: trdy_n and stop_n are never low unless devsel_n is low.
- R5: For a configuration or I/O access, stop_n and trdy_n go low in the same clock, and stop_oe goes high in that clock with no earlier clock of driving stop_n high.
- R6: When a disconnect transfer completes while frame_n is still low, trdy_n goes high and stop_n and devsel_n stay low until frame_n is sampled high.
- R7: For a memory access, stop_oe is high and stop_n stays high. trdy_n stays low over wait states and further transfers until the final transfer.
- R8: rf_strobe is high in exactly the clocks where trdy_n and irdy_n are both low. A configuration or I/O access gives exactly one strobe. rf_write equals cmd bit 0 of the claimed access. rf_space encodes 1 for configuration, 2 for I/O and 3 for memory.
- R9: The clock after the final transfer (irdy_n and trdy_n low with frame_n high) drives all three signals high with the enables still high. The enables drop in the following clock.
- R10: An address phase in that drive-high clock is decoded, and devsel_n goes low two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Sampled FRAME#, active low |
| irdy_n | input | 1 | Sampled IRDY#, active low |
| idsel | input | 1 | Configuration select |
| cmd | input | 4 | Bus command in the address phase |
| ad_low | input | 2 | Low address bits in the address phase |
| hit | input | 1 | Base-address decode hit for I/O and memory |
| devsel_n | output | 1 | DEVSEL# drive value |
| devsel_oe | output | 1 | DEVSEL# output enable |
| trdy_n | output | 1 | TRDY# drive value |
| trdy_oe | output | 1 | TRDY# output enable |
| stop_n | output | 1 | STOP# drive value |
| stop_oe | output | 1 | STOP# output enable |
| rf_strobe | output | 1 | Register-file access strobe, one clock per transfer |
| rf_write | output | 1 | Access direction of the current transaction, 1 = write |
| rf_space | output | 2 | Address space of the current transaction |

## Verification
Configuration and I/O accesses are run both as single transfers and as burst attempts with frame_n held low. The burst attempt shows whether the block holds STOP# until the initiator lets go and gives only one strobe. A memory burst with a wait state in the middle shows that a memory access keeps transferring and drives STOP# high where a configuration access would disconnect. Unclaimed phases (no hit, idsel low, a reserved command) show that nothing is driven. A back-to-back pair shows the turnaround clock being used for a fresh decode.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_HOLD,
        ST_PARK
    } tgt_state_e;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_CFG  = 2'd1,
        SP_IO   = 2'd2,
        SP_MEM  = 2'd3
    } space_e;

    typedef struct packed {
        tgt_state_e st;
        space_e     sp;
        logic       wr;
        logic       frame_prev;
        logic       devsel_n;
        logic       trdy_n;
        logic       stop_n;
        logic       devsel_oe;
        logic       trdy_oe;
        logic       stop_oe;
    } seq_t;

    localparam int CMD_W   = 4;
    localparam int LOW_W   = 2;
    localparam int SPACE_W = 2;

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic [LOW_W-1:0] ad_low,
    input  logic             idsel,
    input  logic             hit,
    output space_e           space
);
    logic cfg_cmd, io_cmd, mem_cmd;

    always_comb begin
        cfg_cmd = (cmd[CMD_W-1:1] == 3'b101);
        io_cmd  = (cmd[CMD_W-1:1] == 3'b001);
        mem_cmd = (cmd[CMD_W-1:1] == 3'b011) || (cmd == 4'b1100) ||
                  (cmd[CMD_W-1:1] == 3'b111);
        if (cfg_cmd && idsel && (ad_low == '0)) begin
            space = SP_CFG;
        end else if (io_cmd && hit) begin
            space = SP_IO;
        end else if (mem_cmd && hit) begin
            space = SP_MEM;
        end else begin
            space = SP_NONE;
        end
    end
endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
    import pci_tgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_n,
    input  logic   irdy_n,
    input  space_e space,
    input  logic   wr_in,
    output seq_t   cur,
    output logic   strobe
);
    seq_t d, q;
    logic addr_phase, xfer, single_only;

    always_comb begin
        d           = q;
        d.frame_prev = frame_n;
        addr_phase  = !frame_n && q.frame_prev;
        xfer        = (q.st == ST_XFER) && !irdy_n && !q.trdy_n;
        single_only = (q.sp == SP_CFG) || (q.sp == SP_IO);
        case (q.st)
            ST_IDLE, ST_PARK: begin
                d.st        = ST_IDLE;
                d.devsel_n  = 1'b1;
                d.trdy_n    = 1'b1;
                d.stop_n    = 1'b1;
                d.devsel_oe = 1'b0;
                d.trdy_oe   = 1'b0;
                d.stop_oe   = 1'b0;
                if (addr_phase && space != SP_NONE) begin
                    d.st = ST_WAIT;
                    d.sp = space;
                    d.wr = wr_in;
                end
            end
            ST_WAIT: begin
                d.st        = ST_XFER;
                d.devsel_n  = 1'b0;
                d.trdy_n    = 1'b0;
                d.stop_n    = !single_only;
                d.devsel_oe = 1'b1;
                d.trdy_oe   = 1'b1;
                d.stop_oe   = 1'b1;
            end
            ST_XFER: begin
                if (xfer) begin
                    if (frame_n) begin
                        d.st       = ST_PARK;
                        d.devsel_n = 1'b1;
                        d.trdy_n   = 1'b1;
                        d.stop_n   = 1'b1;
                    end else if (single_only) begin
                        d.st     = ST_HOLD;
                        d.trdy_n = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (frame_n) begin
                    d.st       = ST_PARK;
                    d.devsel_n = 1'b1;
                    d.stop_n   = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sp: SP_NONE, wr: 1'b0, frame_prev: 1'b1,
                   devsel_n: 1'b1, trdy_n: 1'b1, stop_n: 1'b1,
                   devsel_oe: 1'b0, trdy_oe: 1'b0, stop_oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cur    = q;
    assign strobe = (q.st == ST_XFER) && !irdy_n && !q.trdy_n;
endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
    import pci_tgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic               idsel,
    input  logic [CMD_W-1:0]   cmd,
    input  logic [LOW_W-1:0]   ad_low,
    input  logic               hit,
    output logic               devsel_n,
    output logic               devsel_oe,
    output logic               trdy_n,
    output logic               trdy_oe,
    output logic               stop_n,
    output logic               stop_oe,
    output logic               rf_strobe,
    output logic               rf_write,
    output logic [SPACE_W-1:0] rf_space
);
    space_e dec_space;
    seq_t   st;

    pci_tgt_decode u_dec (
        .cmd    (cmd),
        .ad_low (ad_low),
        .idsel  (idsel),
        .hit    (hit),
        .space  (dec_space)
    );

    pci_tgt_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .space   (dec_space),
        .wr_in   (cmd[0]),
        .cur     (st),
        .strobe  (rf_strobe)
    );

    assign devsel_n  = st.devsel_n;
    assign devsel_oe = st.devsel_oe;
    assign trdy_n    = st.trdy_n;
    assign trdy_oe   = st.trdy_oe;
    assign stop_n    = st.stop_n;
    assign stop_oe   = st.stop_oe;
    assign rf_write  = st.wr;
    assign rf_space  = st.sp;
endmodule

// File: rtl/pci_tgt_ctrl_chk.sv
module pci_tgt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic       irdy_n,
    input logic       devsel_n,
    input logic       devsel_oe,
    input logic       trdy_n,
    input logic       trdy_oe,
    input logic       stop_n,
    input logic       stop_oe,
    input logic       rf_strobe,
    input logic [1:0] rf_space
);
    p_trdy_needs_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);
    p_stop_needs_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !devsel_n);
    p_enables_when_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n || !trdy_n || !stop_n) |-> (devsel_oe && trdy_oe && stop_oe));
    p_disconnect_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && (rf_space == 2'd1 || rf_space == 2'd2)) |-> !stop_n);
    p_stop_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !frame_n) |=> !stop_n);
    p_strobe_transfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_strobe |-> (!trdy_n && !irdy_n));
    p_final_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=>
        (devsel_n && trdy_n && stop_n && devsel_oe && trdy_oe && stop_oe));
    p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_oe) |-> $past(devsel_n));
endmodule

bind pci_tgt_ctrl pci_tgt_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .devsel_n  (devsel_n),
    .devsel_oe (devsel_oe),
    .trdy_n    (trdy_n),
    .trdy_oe   (trdy_oe),
    .stop_n    (stop_n),
    .stop_oe   (stop_oe),
    .rf_strobe (rf_strobe),
    .rf_space  (rf_space)
);

// File: tb/tb_pci_tgt_ctrl.sv
module tb_pci_tgt_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_n, irdy_n, idsel, hit;
    logic [3:0] cmd;
    logic [1:0] ad_low;
    logic       devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe;
    logic       rf_strobe, rf_write;
    logic [1:0] rf_space;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    // packed view: devsel_n devsel_oe trdy_n trdy_oe stop_n stop_oe strobe
    localparam logic [6:0] REL   = 7'b1010100;
    localparam logic [6:0] PARK  = 7'b1111110;
    localparam logic [6:0] DISC  = 7'b0101011;
    localparam logic [6:0] HOLD  = 7'b0111010;
    localparam logic [6:0] MXFER = 7'b0101111;
    localparam logic [6:0] MWAIT = 7'b0101110;

    always #10 clk = ~clk;

    pci_tgt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .cmd(cmd), .ad_low(ad_low), .hit(hit),
        .devsel_n(devsel_n), .devsel_oe(devsel_oe), .trdy_n(trdy_n),
        .trdy_oe(trdy_oe), .stop_n(stop_n), .stop_oe(stop_oe),
        .rf_strobe(rf_strobe), .rf_write(rf_write), .rf_space(rf_space)
    );

    task automatic cyc(input logic f, input logic i, input logic [3:0] c,
                       input logic sel, input logic h);
        @(posedge clk);
        #1;
        frame_n = f; irdy_n = i; cmd = c; idsel = sel; hit = h; ad_low = 2'b00;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
    endtask

    task automatic chk(input string req, input logic [6:0] exp);
        logic [6:0] act;
        act = {devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe, rf_strobe};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_attr(input string req, input logic w, input logic [1:0] sp);
        n_chk++;
        if (rf_write !== w || rf_space !== sp) begin
            n_fail++;
            $display("FAIL %s: write/space actual %b/%0d expected %b/%0d",
                     req, rf_write, rf_space, w, sp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0; hit = 1'b0;
        cmd = 4'h0; ad_low = 2'b00;
        repeat (3) @(negedge clk);
        chk("R1 reset", REL);
        rst_n = 1'b1;
        idle();
        chk("R1 after release", REL);
    endtask

    // configuration write, single transfer
    task automatic t_cfg_single();
        cyc(1'b0, 1'b1, 4'b1011, 1'b1, 1'b0);
        chk("R2 address clock", REL);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R3 nothing in first clock", REL);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R5 cfg stop with trdy", DISC);
        chk_attr("R8 cfg write attr", 1'b1, 2'd1);
        cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
        chk("R9 drive high", PARK);
        idle();
        chk("R9 released", REL);
    endtask

    // configuration read tried as a burst
    task automatic t_cfg_burst();
        cyc(1'b0, 1'b1, 4'b1010, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R3 cfg burst decode clock", REL);
        cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R5 R8 cfg burst transfer", DISC);
        chk_attr("R8 cfg read attr", 1'b0, 2'd1);
        cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R6 stop held frame low", HOLD);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R6 R8 stop held no second strobe", HOLD);
        cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
        chk("R9 after hold", PARK);
        idle();
        chk("R9 released after hold", REL);
    endtask

    // I/O read with a wait state from the initiator
    task automatic t_io();
        cyc(1'b0, 1'b1, 4'b0010, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
        chk("R5 io stop with trdy, waiting", 7'b0101010);
        chk_attr("R8 io attr", 1'b0, 2'd2);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R8 io strobe", DISC);
        cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
        chk("R9 io drive high", PARK);
        idle();
    endtask

    // memory write burst: transfer, wait, transfer, final
    task automatic t_mem_burst();
        cyc(1'b0, 1'b1, 4'b0111, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R7 mem first transfer", MXFER);
        chk_attr("R8 mem attr", 1'b1, 2'd3);
        cyc(1'b0, 1'b1, 4'h0, 1'b0, 1'b0);
        chk("R7 mem wait state", MWAIT);
        cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R7 mem second transfer", MXFER);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R7 mem final transfer", MXFER);
        cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
        chk("R9 mem drive high", PARK);
        idle();
        chk("R9 mem released", REL);
    endtask

    // address phases that must not be claimed
    task automatic t_unclaimed();
        logic [3:0] cmds [3] = '{4'b0111, 4'b1011, 4'b0100};
        logic       sels [3] = '{1'b0, 1'b0, 1'b1};
        logic       hits [3] = '{1'b0, 1'b1, 1'b1};
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b1, cmds[k], sels[k], hits[k]);
            cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
            cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
            chk("R2 unclaimed", REL);
            cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
            chk("R2 unclaimed later", REL);
            idle();
        end
    endtask

    // memory single followed at once by a configuration write
    task automatic t_b2b();
        cyc(1'b0, 1'b1, 4'b0110, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R7 b2b mem single", MXFER);
        cyc(1'b0, 1'b1, 4'b1011, 1'b1, 1'b0);
        chk("R10 park with new address", PARK);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R10 released in decode clock", REL);
        cyc(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        chk("R10 second transaction claimed", DISC);
        chk_attr("R10 second attr", 1'b1, 2'd1);
        cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
        chk("R10 second drive high", PARK);
        idle();
    endtask

    initial begin
        t_reset();
        t_cfg_single();
        t_cfg_burst();
        t_io();
        t_mem_burst();
        t_unclaimed();
        t_b2b();
        idle();
        chk("R1 idle at end", REL);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule